// File: doc/BRIEF.md
# Windowed Call, Entry and Return Sequencer

This block keeps the register-window bookkeeping for a processor with a rotating register file. The register file holds `NUM_PHYS_REGS` physical registers, grouped into frames of four. The block owns three pieces of state:

- the window base, which selects the frame seen as logical register 0;
- a one-bit-per-frame live-frame vector;
- the call-increment field of the processor status.

The decode stage sends one command per strobe: a windowed call, a subroutine entry, a windowed return, or a stack-pointer move check. On a call, the block records the call increment. It also produces the return link, which is the call increment in the two top bits with the low bits of the next PC below it.

On entry, the block computes the new stack pointer and asks the register file to rotate by the call increment. It then marks the new frame as live. On return, the block reads the increment carried in the link and checks it against the nearest live frame below the current one. It then rotates back by that increment. The result is either a return PC together with the old frame released, or a window-underflow request with the status fields a handler needs. The register spill and fill traffic belongs to the exception handlers and is not part of this block.

Every result is registered and appears in the cycle after the strobe.

Top module: `wincall_unit`

## Requirements
- R1: After reset, the window base is 0, the live-frame vector holds only bit 0 (value 1), the call-increment field is 0, and rf_we, rot_valid, ret_valid, exc_valid and excm_set are all low.
- R2: A call with increment k in 1..3 sets ps_callinc to k. It writes logical register 4*k with {k, cmd_link_pc}, where k occupies the two top bits. A call with k = 0 instead raises exception code 1 (illegal), performs no write, and leaves ps_callinc unchanged.
- R3: An entry is illegal when cmd_sreg > 3, or when ps_woe is not 1, or when ps_excm is not 0. An illegal entry raises exception code 1, performs no write, requests no rotation, and leaves wbase and wstart unchanged.
- R4: A legal entry does four things:
  - it writes logical register {ps_callinc, cmd_sreg[1:0]} with cmd_val - cmd_imm*8;
  - it requests a rotation with rot_delta = ps_callinc;
  - it advances wbase by ps_callinc, modulo NUM_PHYS_REGS/4;
  - it sets the wstart bit at the new wbase.
- R5: For a return, n = cmd_val[31:30]. The depth m is 1, 2 or 3 for the first set wstart bit found at wbase-1, wbase-2 or wbase-3 (checked in that order), and 0 if none of these bits is set. The return is illegal when n = 0, when m != 0 and m != n, or when the ps_woe/ps_excm condition of R3 fails. An illegal return raises exception code 1 and changes no state.
- R6: A legal return requests a rotation with rot_delta = -n, in two's complement of the wbase width, and moves wbase back by n.
- R7: After a legal return, if the wstart bit at the new wbase is set, the bit of the old wbase is cleared. ret_valid is then pulsed with ret_pc = {cmd_pc[31:30], cmd_val[29:0]}.
- R8: After a legal return, if the wstart bit at the new wbase is clear, the block raises an underflow instead. The exception code is 3, 4 or 5 for n = 1, 2 or 3. excm_set pulses, ps_owb takes the old wbase, epc takes cmd_pc, wstart is unchanged, and ret_valid stays low. ps_owb and epc hold their values until the next underflow.
- R9: A stack-pointer move check raises exception code 2 (alloca) when none of the wstart bits at wbase-1, wbase-2 and wbase-3 is set. Otherwise it produces no output.
- R10: Every result appears in the cycle after the strobe and lasts exactly one cycle. No output pulse occurs without a strobe. At most one of ret_valid and exc_valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 call, 1 entry, 2 return, 3 stack-pointer move check |
| cmd_inc | input | 2 | Call increment of a call |
| cmd_sreg | input | 4 | Stack register index of an entry |
| cmd_imm | input | 12 | Frame size of an entry, in units of 8 bytes |
| cmd_val | input | XLEN | Entry: stack register value; return: logical register 0 |
| cmd_pc | input | XLEN | PC of the command |
| cmd_link_pc | input | XLEN-2 | Low bits of the PC after the call |
| ps_woe | input | 1 | Window overflow enable |
| ps_excm | input | 1 | Exception mode |
| ps_callinc | output | 2 | Call-increment status field |
| wbase | output | WB_W | Window base |
| wstart | output | NUM_PHYS_REGS/4 | Live-frame vector |
| rf_we | output | 1 | Logical register write strobe |
| rf_waddr | output | 4 | Logical register index |
| rf_wdata | output | XLEN | Write data |
| rot_valid | output | 1 | Rotation request to the register file |
| rot_delta | output | WB_W | Signed rotation amount |
| ret_valid | output | 1 | Return target valid |
| ret_pc | output | XLEN | Return target |
| exc_valid | output | 1 | Exception request |
| exc_kind | output | 3 | 1 illegal, 2 alloca, 3/4/5 underflow of 4/8/12 |
| excm_set | output | 1 | Set exception mode |
| ps_owb | output | WB_W | Saved old window base |
| epc | output | XLEN | Saved exception PC |

## Verification
Some properties are checked by the in-line properties on every cycle:
- a return and an exception are never reported together;
- every rotation moves wbase by exactly the requested delta;
- a completed return leaves the new frame live and the old frame released;
- an entry leaves its new frame live;
- an underflow always carries the old base and sets exception mode;
- a call link's top bits always match the register it is written to.

The legality decisions, the priority search for the depth m, and base wrap-around across the top frame all depend on the exact history of the live-frame vector. These can only be shown by the bench's directed sequences and its random command streams, checked against a reference model.

// File: rtl/wincall_pkg.sv
package wincall_pkg;
   typedef enum logic [1:0] {
      OP_CALL  = 2'd0,
      OP_ENTRY = 2'd1,
      OP_RETW  = 2'd2,
      OP_MOVSP = 2'd3
   } wc_op_e;

   typedef enum logic [2:0] {
      EXC_NONE    = 3'd0,
      EXC_ILLEGAL = 3'd1,
      EXC_ALLOCA  = 3'd2,
      EXC_UF4     = 3'd3,
      EXC_UF8     = 3'd4,
      EXC_UF12    = 3'd5
   } wc_exc_e;
endpackage

// File: rtl/wincall_probe.sv
// Looks at the three frames below the current base and reports the
// nearest live one (1..3) or 0, plus whether any of them is live.
module wincall_probe #(
   parameter int WB_W = 4,
   localparam int NW = 1 << WB_W
) (
   input  logic [NW-1:0]   wstart,
   input  logic [WB_W-1:0] wbase,
   output logic [1:0]      depth,
   output logic            live
);
   logic [2:0] hit;

   for (genvar d = 1; d <= 3; d++) begin : g_look
      assign hit[d-1] = wstart[wbase - WB_W'(d)];
   end

   always_comb begin
      if (hit[0])      depth = 2'd1;
      else if (hit[1]) depth = 2'd2;
      else if (hit[2]) depth = 2'd3;
      else             depth = 2'd0;
   end

   assign live = |hit;
endmodule

// File: rtl/wincall_wsupd.sv
// Per-frame set/clear of the live-frame vector.
module wincall_wsupd #(
   parameter int WB_W = 4,
   localparam int NW = 1 << WB_W
) (
   input  logic [NW-1:0]   cur,
   input  logic            set_en,
   input  logic [WB_W-1:0] set_idx,
   input  logic            clr_en,
   input  logic [WB_W-1:0] clr_idx,
   output logic [NW-1:0]   nxt
);
   for (genvar i = 0; i < NW; i++) begin : g_bit
      assign nxt[i] = (cur[i] & ~(clr_en && clr_idx == WB_W'(i)))
                    | (set_en && set_idx == WB_W'(i));
   end
endmodule

// File: rtl/wincall_unit.sv
module wincall_unit
   import wincall_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int NUM_PHYS_REGS = 64,
   localparam int NW   = NUM_PHYS_REGS / 4,
   localparam int WB_W = $clog2(NW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [1:0]        cmd_inc,
   input  logic [3:0]        cmd_sreg,
   input  logic [11:0]       cmd_imm,
   input  logic [XLEN-1:0]   cmd_val,
   input  logic [XLEN-1:0]   cmd_pc,
   input  logic [XLEN-3:0]   cmd_link_pc,
   input  logic              ps_woe,
   input  logic              ps_excm,
   output logic [1:0]        ps_callinc,
   output logic [WB_W-1:0]   wbase,
   output logic [NW-1:0]     wstart,
   output logic              rf_we,
   output logic [3:0]        rf_waddr,
   output logic [XLEN-1:0]   rf_wdata,
   output logic              rot_valid,
   output logic [WB_W-1:0]   rot_delta,
   output logic              ret_valid,
   output logic [XLEN-1:0]   ret_pc,
   output logic              exc_valid,
   output logic [2:0]        exc_kind,
   output logic              excm_set,
   output logic [WB_W-1:0]   ps_owb,
   output logic [XLEN-1:0]   epc
);
   if (NUM_PHYS_REGS < 16 || (NUM_PHYS_REGS & (NUM_PHYS_REGS - 1)) != 0) begin : g_bad_nregs
      $error("NUM_PHYS_REGS must be a power of two of at least 16");
   end
   if (XLEN < 16) begin : g_bad_xlen
      $error("XLEN must be at least 16");
   end

   wc_op_e           op;
   logic [1:0]       ci_q, ci_d;
   logic [WB_W-1:0]  wb_q, wb_d;
   logic [NW-1:0]    ws_q, ws_d;
   logic [1:0]       depth;
   logic             live, win_ok;
   logic [1:0]       ret_n;
   logic             set_en, clr_en;
   logic [WB_W-1:0]  set_idx, clr_idx;

   logic             we_d, rot_d, ret_d, exv_d, excm_d;
   logic [3:0]       waddr_d;
   logic [XLEN-1:0]  wdata_d, retpc_d, epc_d;
   logic [WB_W-1:0]  delta_d, owb_d;
   wc_exc_e          kind_d;

   assign op     = wc_op_e'(cmd_op);
   assign win_ok = ps_woe && !ps_excm;
   assign ret_n  = cmd_val[XLEN-1:XLEN-2];

   wincall_probe #(.WB_W(WB_W)) u_probe (
      .wstart (ws_q), .wbase (wb_q), .depth (depth), .live (live)
   );

   wincall_wsupd #(.WB_W(WB_W)) u_wsupd (
      .cur (ws_q), .set_en (set_en), .set_idx (set_idx),
      .clr_en (clr_en), .clr_idx (clr_idx), .nxt (ws_d)
   );

   always_comb begin
      ci_d = ci_q;  wb_d = wb_q;
      set_en = 1'b0;  set_idx = '0;  clr_en = 1'b0;  clr_idx = '0;
      we_d = 1'b0;  waddr_d = rf_waddr;  wdata_d = rf_wdata;
      rot_d = 1'b0;  delta_d = rot_delta;
      ret_d = 1'b0;  retpc_d = ret_pc;
      exv_d = 1'b0;  kind_d = EXC_NONE;
      excm_d = 1'b0;  owb_d = ps_owb;  epc_d = epc;
      if (cmd_valid) begin
         unique case (op)
            OP_CALL: begin
               if (cmd_inc == 2'd0) begin
                  exv_d = 1'b1;  kind_d = EXC_ILLEGAL;
               end else begin
                  ci_d    = cmd_inc;
                  we_d    = 1'b1;
                  waddr_d = {cmd_inc, 2'b00};
                  wdata_d = {cmd_inc, cmd_link_pc};
               end
            end
            OP_ENTRY: begin
               if (cmd_sreg > 4'd3 || !win_ok) begin
                  exv_d = 1'b1;  kind_d = EXC_ILLEGAL;
               end else begin
                  we_d    = 1'b1;
                  waddr_d = {ci_q, cmd_sreg[1:0]};
                  wdata_d = cmd_val - XLEN'({cmd_imm, 3'b000});
                  rot_d   = 1'b1;
                  delta_d = WB_W'(ci_q);
                  wb_d    = wb_q + WB_W'(ci_q);
                  set_en  = 1'b1;
                  set_idx = wb_d;
               end
            end
            OP_RETW: begin
               if (ret_n == 2'd0 || (depth != 2'd0 && depth != ret_n) || !win_ok) begin
                  exv_d = 1'b1;  kind_d = EXC_ILLEGAL;
               end else begin
                  rot_d   = 1'b1;
                  delta_d = WB_W'(0) - WB_W'(ret_n);
                  wb_d    = wb_q - WB_W'(ret_n);
                  if (ws_q[wb_d]) begin
                     clr_en  = 1'b1;
                     clr_idx = wb_q;
                     ret_d   = 1'b1;
                     retpc_d = {cmd_pc[XLEN-1:XLEN-2], cmd_val[XLEN-3:0]};
                  end else begin
                     exv_d  = 1'b1;
                     kind_d = wc_exc_e'(3'd2 + {1'b0, ret_n});
                     excm_d = 1'b1;
                     owb_d  = wb_q;
                     epc_d  = cmd_pc;
                  end
               end
            end
            OP_MOVSP: begin
               if (!live) begin
                  exv_d = 1'b1;  kind_d = EXC_ALLOCA;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ci_q <= '0;  wb_q <= '0;  ws_q <= NW'(1);
         rf_we <= 1'b0;  rf_waddr <= '0;  rf_wdata <= '0;
         rot_valid <= 1'b0;  rot_delta <= '0;
         ret_valid <= 1'b0;  ret_pc <= '0;
         exc_valid <= 1'b0;  exc_kind <= EXC_NONE;
         excm_set <= 1'b0;  ps_owb <= '0;  epc <= '0;
      end else begin
         ci_q <= ci_d;  wb_q <= wb_d;  ws_q <= ws_d;
         rf_we <= we_d;  rf_waddr <= waddr_d;  rf_wdata <= wdata_d;
         rot_valid <= rot_d;  rot_delta <= delta_d;
         ret_valid <= ret_d;  ret_pc <= retpc_d;
         exc_valid <= exv_d;  exc_kind <= kind_d;
         excm_set <= excm_d;  ps_owb <= owb_d;  epc <= epc_d;
      end
   end

   assign ps_callinc = ci_q;
   assign wbase      = wb_q;
   assign wstart     = ws_q;

   // R10: a return and an exception never coincide
   p_single_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ret_valid, exc_valid}));

   // R6: each rotation moves the base by the requested delta
   p_rot_moves_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rot_valid |-> wbase == $past(wbase) + rot_delta);

   // R7: a completed return leaves new frame live and old frame released
   p_ret_frames_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> (wstart[wbase] && !wstart[$past(wbase)]));

   // R4: an entry leaves its new frame live
   p_entry_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_valid && !ret_valid && !excm_set) |-> wstart[wbase]);

   // R8: underflow saves the old base and sets exception mode
   p_underflow_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_kind >= 3'd3) |-> (excm_set && ps_owb == $past(wbase)
                                           && $stable(wstart)));

   // R2: a call link carries its increment in the top bits
   p_call_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && !rot_valid) |-> (rf_wdata[XLEN-1:XLEN-2] == rf_waddr[3:2]
                                 && ps_callinc == rf_waddr[3:2]));
endmodule

// File: tb/sim_wincall_unit.sv
`timescale 1ns/1ps
module sim_wincall_unit;
   localparam int XLEN = 32;
   localparam int NPR  = 64;
   localparam int NW   = NPR / 4;
   localparam int WB_W = $clog2(NW);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = '0, cmd_inc = '0;
   logic [3:0] cmd_sreg = '0;
   logic [11:0] cmd_imm = '0;
   logic [XLEN-1:0] cmd_val = '0, cmd_pc = '0;
   logic [XLEN-3:0] cmd_link_pc = '0;
   logic ps_woe = 1'b1, ps_excm = 1'b0;
   logic [1:0] ps_callinc;
   logic [WB_W-1:0] wbase, rot_delta, ps_owb;
   logic [NW-1:0] wstart;
   logic rf_we, rot_valid, ret_valid, exc_valid, excm_set;
   logic [3:0] rf_waddr;
   logic [XLEN-1:0] rf_wdata, ret_pc, epc;
   logic [2:0] exc_kind;

   int total = 0, bad = 0;
   bit done = 1'b0;

   logic [1:0] m_ci;
   logic [WB_W-1:0] m_wb, m_owb;
   logic [NW-1:0] m_ws;
   logic [XLEN-1:0] m_epc;

   always #2.5 clk = ~clk;

   wincall_unit #(.XLEN(XLEN), .NUM_PHYS_REGS(NPR)) u0 (
      .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_inc, .cmd_sreg, .cmd_imm,
      .cmd_val, .cmd_pc, .cmd_link_pc, .ps_woe, .ps_excm, .ps_callinc,
      .wbase, .wstart, .rf_we, .rf_waddr, .rf_wdata, .rot_valid, .rot_delta,
      .ret_valid, .ret_pc, .exc_valid, .exc_kind, .excm_set, .ps_owb, .epc);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] depth_of(input logic [NW-1:0] ws, input logic [WB_W-1:0] wb);
      for (int d = 1; d <= 3; d++)
         if (ws[wb - WB_W'(d)]) return 2'(d);
      return 2'd0;
   endfunction

   task automatic run_cmd(input logic [1:0] op, input logic [1:0] inc,
                          input logic [3:0] sreg, input logic [11:0] imm,
                          input logic [31:0] val, input logic [31:0] pc,
                          input logic [31:0] npc, input bit woe, input bit excm);
      bit e_we = 0, e_rot = 0, e_ret = 0, e_exc = 0, e_excm = 0;
      logic [3:0] e_wa = '0;
      logic [31:0] e_wd = '0, e_rpc = '0;
      logic [WB_W-1:0] e_dl = '0, nb;
      logic [2:0] e_kind = 3'd0;
      logic [1:0] n, m;
      string tag;
      bit ok;
      case (op)
         2'd0: begin
            tag = "R2";
            if (inc == 0) begin e_exc = 1; e_kind = 3'd1; end
            else begin
               m_ci = inc; e_we = 1; e_wa = {inc, 2'b00};
               e_wd = {inc, npc[29:0]};
            end
         end
         2'd1: begin
            if (sreg > 3 || !woe || excm) begin
               tag = "R3"; e_exc = 1; e_kind = 3'd1;
            end else begin
               tag = "R4"; e_we = 1; e_wa = {m_ci, sreg[1:0]};
               e_wd = val - {17'd0, imm, 3'd0};
               e_rot = 1; e_dl = WB_W'(m_ci);
               m_wb = m_wb + WB_W'(m_ci); m_ws[m_wb] = 1'b1;
            end
         end
         2'd2: begin
            n = val[31:30]; m = depth_of(m_ws, m_wb);
            if (n == 0 || (m != 0 && m != n) || !woe || excm) begin
               tag = "R5"; e_exc = 1; e_kind = 3'd1;
            end else begin
               e_rot = 1; e_dl = WB_W'(0) - WB_W'(n);
               nb = m_wb - WB_W'(n);
               if (m_ws[nb]) begin
                  tag = "R7"; m_ws[m_wb] = 1'b0; e_ret = 1;
                  e_rpc = {pc[31:30], val[29:0]};
               end else begin
                  tag = "R8"; e_exc = 1; e_kind = 3'd2 + {1'b0, n};
                  e_excm = 1; m_owb = m_wb; m_epc = pc;
               end
               m_wb = nb;
            end
         end
         default: begin
            tag = "R9";
            if (depth_of(m_ws, m_wb) == 0) begin e_exc = 1; e_kind = 3'd2; end
         end
      endcase
      @(negedge clk);
      cmd_op = op; cmd_inc = inc; cmd_sreg = sreg; cmd_imm = imm; cmd_val = val;
      cmd_pc = pc; cmd_link_pc = npc[29:0]; ps_woe = woe; ps_excm = excm;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(exc_valid == e_exc && (!e_exc || exc_kind == e_kind), {tag, " exc"},
          {28'd0, exc_valid, exc_kind}, {28'd0, e_exc, e_kind});
      ok = rf_we == e_we && (!e_we || (rf_waddr == e_wa && rf_wdata == e_wd));
      chk(ok, {tag, " write"}, rf_wdata, e_wd);
      ok = rot_valid == e_rot && (!e_rot || rot_delta == e_dl);
      chk(ok, {tag, " R6 rotate"}, {27'd0, rot_valid, rot_delta}, {27'd0, e_rot, e_dl});
      chk(ret_valid == e_ret && (!e_ret || ret_pc == e_rpc), {tag, " ret"}, ret_pc, e_rpc);
      ok = excm_set == e_excm && ps_owb == m_owb && epc == m_epc;
      chk(ok, {tag, " R8 status"}, epc, m_epc);
      ok = wbase == m_wb && wstart == m_ws && ps_callinc == m_ci;
      chk(ok, {tag, " state"}, {10'd0, ps_callinc, wbase, wstart},
          {10'd0, m_ci, m_wb, m_ws});
   endtask

   task automatic idle_check();
      @(negedge clk);
      chk(!rf_we && !rot_valid && !ret_valid && !exc_valid && !excm_set,
          "R10 idle pulses", {27'd0, rf_we, rot_valid, ret_valid, exc_valid, excm_set}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_ci = '0; m_wb = '0; m_ws = NW'(1); m_owb = '0; m_epc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wbase == 0 && wstart == NW'(1) && ps_callinc == 0, "R1 reset state",
          {10'd0, ps_callinc, wbase, wstart}, {10'd0, 2'd0, 4'd0, 16'd1});
      chk(!rf_we && !rot_valid && !ret_valid && !exc_valid && !excm_set, "R1 reset pulses",
          {27'd0, rf_we, rot_valid, ret_valid, exc_valid, excm_set}, 32'd0);
      // directed corner cases
      run_cmd(2'd0, 2'd1, 0, 0, 0, 0, 32'h1234_5678, 1, 0);          // R2 call
      idle_check();                                                    // R10
      run_cmd(2'd1, 0, 4'd1, 12'd4, 32'h1000, 0, 0, 1, 0);             // R4 entry
      run_cmd(2'd2, 0, 0, 0, 32'h4000_0100, 32'hC000_0000, 0, 1, 0);   // R7 return
      run_cmd(2'd3, 0, 0, 0, 0, 0, 0, 1, 0);                           // R9 alloca
      run_cmd(2'd2, 0, 0, 0, 32'h4000_0200, 32'h8000_0040, 0, 1, 0);   // R8 underflow, wrap
      run_cmd(2'd1, 0, 4'd4, 12'd1, 32'h2000, 0, 0, 1, 0);             // R3 sreg>3
      run_cmd(2'd1, 0, 4'd2, 12'd1, 32'h2000, 0, 0, 1, 1);             // R3 excm set
      run_cmd(2'd1, 0, 4'd2, 12'd1, 32'h2000, 0, 0, 0, 0);             // R3 woe clear
      run_cmd(2'd2, 0, 0, 0, 32'h0000_0010, 0, 0, 1, 0);               // R5 n=0
      run_cmd(2'd0, 2'd2, 0, 0, 0, 0, 32'h0000_0444, 1, 0);
      run_cmd(2'd1, 0, 4'd1, 12'd2, 32'h3000, 0, 0, 1, 0);             // R4 wrap past top
      run_cmd(2'd2, 0, 0, 0, 32'hC000_0300, 0, 0, 1, 0);               // R5 m!=n
      run_cmd(2'd3, 0, 0, 0, 0, 0, 0, 1, 0);                           // R9 no alloca
      run_cmd(2'd0, 2'd0, 0, 0, 0, 0, 32'h99, 1, 0);                   // R2 inc 0
      run_cmd(2'd0, 2'd3, 0, 0, 0, 0, 32'hFFFF_FFFF, 1, 0);            // R2 inc 3
      run_cmd(2'd1, 0, 4'd3, 12'hFFF, 32'h0001_0000, 0, 0, 1, 0);
      run_cmd(2'd2, 0, 0, 0, 32'hC000_0ABC, 32'h4000_0000, 0, 1, 0);   // R8 UF12 or R7
      idle_check();
      // random stream
      for (int i = 0; i < 1500; i++) begin
         logic [1:0] op = 2'($urandom % 4);
         logic [31:0] v = $urandom;
         if (op == 2'd2 && ($urandom % 2) == 1) v[31:30] = m_ci;
         run_cmd(op, 2'($urandom % 4), 4'($urandom % 6), 12'($urandom),
                 v, $urandom, $urandom, ($urandom % 10) != 0, ($urandom % 10) == 0);
         if (i % 50 == 0) idle_check();
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule